// File: doc/BRIEF.md
# DMA Interrupt Coalescing Counter

This block lives inside one DMA channel and turns a stream of packet-completion events into a smaller number of CPU interrupts. An 8-bit coalescing counter starts from a programmable threshold. Each qualifying completion event counts it down. When the terminal event arrives, a 4-bit pending-interrupt counter goes up by one, and the coalescing counter starts again from the threshold.

The CPU sees one interrupt line. That line is high while any interrupt is pending and the channel's interrupt enable is set. Software retires pending interrupts one at a time with an acknowledge strobe. The coalescing count can be restarted from the threshold in two ways: by a software load strobe, or by a delay-timer pulse when timer reloads are enabled. The current coalescing count, the threshold and the pending count are brought out as readable fields.

Top module: `irq_coalesce_ctr`

## Requirements
- R1: After reset the coalescing count and the threshold both equal the parameter RST_THRESH (default 4), the pending count is 0, and irq_out is low.
- R2: The completion source is chosen by cfg_use_ioe. When it is 0, evt_eof counts and evt_ioe is ignored. When it is 1, evt_ioe counts and evt_eof is ignored.
- R3: A completion counts only in a cycle where evt_desc_done and evt_fifo_empty are both 1. Otherwise the coalescing count stays as it is.
- R4: A counted completion lowers the coalescing count by one at the next edge. If the count was 1 or 0, the completion is terminal instead: at that same edge the pending count rises by one and the coalescing count reloads from the threshold.
- R5: A write on wr_thr_we stores wr_thr_data as the threshold. The current coalescing count is left alone, and the new value is used from the next reload on.
- R6: A pulse on wr_load reloads the coalescing count from the threshold at the next edge.
- R7: A pulse on tmr_fire reloads the coalescing count only when cfg_dly_en is 1. When cfg_dly_en is 0 the pulse has no effect.
- R8: A reload (load strobe or enabled timer) in the same cycle as a counted completion wins. The completion is dropped and the pending count does not change.
- R9: irq_out is 1 exactly when the pending count is non-zero and cfg_irq_en is 1.
- R10: A pulse on wr_ack lowers a non-zero pending count by one. While the pending count is 0, wr_ack has no effect.
- R11: The pending count saturates at 15. A terminal completion at 15 still reloads the coalescing count but leaves the pending count at 15.
- R12: A terminal completion and an effective acknowledge in the same cycle leave the pending count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_thr_we | input | 1 | Threshold write strobe |
| wr_thr_data | input | 8 | New threshold value |
| wr_load | input | 1 | Force reload of the coalescing count |
| wr_ack | input | 1 | Acknowledge one pending interrupt |
| cfg_use_ioe | input | 1 | 0: count end-of-frame; 1: count descriptor interrupt-on-end |
| cfg_irq_en | input | 1 | Interrupt output enable |
| cfg_dly_en | input | 1 | Allow the delay timer to reload |
| evt_eof | input | 1 | End-of-frame completion |
| evt_ioe | input | 1 | Descriptor interrupt-on-end flag |
| evt_desc_done | input | 1 | Descriptor update finished |
| evt_fifo_empty | input | 1 | Write FIFO toward memory is empty |
| tmr_fire | input | 1 | Delay timer pulse |
| irq_out | output | 1 | Interrupt request to the CPU |
| coal_count | output | 8 | Current coalescing count |
| thr_value | output | 8 | Current threshold |
| pend_count | output | 4 | Pending interrupt count |

## Verification
The pending counter can be pushed up by a terminal completion and pulled down by an acknowledge in the same cycle. The coalescing counter can be asked to reload and to count a completion in the same cycle. The bench provokes both. It sets the threshold to 0 so that every completion is terminal, then drives a completion together with an acknowledge, both at saturation and below it. It then expects the pending count to stay unchanged. It also drives a load strobe together with a valid completion, and expects a plain reload with no change to the pending count.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;
    typedef enum logic {
        SRC_FRAME_END = 1'b0,
        SRC_DESC_FLAG = 1'b1
    } evt_src_e;

    localparam int DEF_CNT_W  = 8;
    localparam int DEF_PEND_W = 4;
endpackage

// File: rtl/irq_evt_qual.sv
module irq_evt_qual
    import irq_coal_pkg::*;
(
    input  logic sel_src,
    input  logic frame_end,
    input  logic desc_flag,
    input  logic desc_done,
    input  logic fifo_empty,
    output logic evt_valid
);
    evt_src_e src;
    logic     raw_evt;

    always_comb begin
        src = evt_src_e'(sel_src);
        case (src)
            SRC_FRAME_END: raw_evt = frame_end;
            SRC_DESC_FLAG: raw_evt = desc_flag;
            default:       raw_evt = 1'b0;
        endcase
        evt_valid = raw_evt & desc_done & fifo_empty;
    end
endmodule

// File: rtl/irq_coal_down.sv
module irq_coal_down #(
    parameter int               CNT_W   = 8,
    parameter logic [CNT_W-1:0] RST_VAL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thr_we,
    input  logic [CNT_W-1:0] thr_wd,
    input  logic             force_ld,
    input  logic             evt,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] thr_o,
    output logic             term_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] thr;
    } down_st_t;

    down_st_t st_d, st_q;
    logic     term_d;

    always_comb begin
        st_d   = st_q;
        term_d = 1'b0;
        if (thr_we) begin
            st_d.thr = thr_wd;
        end
        if (force_ld) begin
            st_d.cnt = st_q.thr;
        end else if (evt) begin
            if (st_q.cnt <= CNT_W'(1)) begin
                term_d   = 1'b1;
                st_d.cnt = st_q.thr;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= RST_VAL;
            st_q.thr <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign thr_o  = st_q.thr;
    assign term_o = term_d;
endmodule

// File: rtl/irq_pend_updn.sv
module irq_pend_updn #(
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              ack,
    output logic [PEND_W-1:0] pend_o
);
    localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

    typedef struct packed {
        logic [PEND_W-1:0] pend;
    } pend_st_t;

    pend_st_t st_d, st_q;
    logic     ack_eff;

    always_comb begin
        st_d    = st_q;
        ack_eff = ack && (st_q.pend != '0);
        if (inc && !ack_eff) begin
            if (st_q.pend != PEND_MAX) begin
                st_d.pend = st_q.pend + PEND_W'(1);
            end
        end else if (ack_eff && !inc) begin
            st_d.pend = st_q.pend - PEND_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/irq_coalesce_ctr.sv
module irq_coalesce_ctr #(
    parameter int                CNT_W      = irq_coal_pkg::DEF_CNT_W,
    parameter int                PEND_W     = irq_coal_pkg::DEF_PEND_W,
    parameter logic [CNT_W-1:0]  RST_THRESH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_thr_we,
    input  logic [CNT_W-1:0]  wr_thr_data,
    input  logic              wr_load,
    input  logic              wr_ack,
    input  logic              cfg_use_ioe,
    input  logic              cfg_irq_en,
    input  logic              cfg_dly_en,
    input  logic              evt_eof,
    input  logic              evt_ioe,
    input  logic              evt_desc_done,
    input  logic              evt_fifo_empty,
    input  logic              tmr_fire,
    output logic              irq_out,
    output logic [CNT_W-1:0]  coal_count,
    output logic [CNT_W-1:0]  thr_value,
    output logic [PEND_W-1:0] pend_count
);
    logic evt_ok;
    logic reload_req;
    logic terminal;

    irq_evt_qual u_qual (
        .sel_src    (cfg_use_ioe),
        .frame_end  (evt_eof),
        .desc_flag  (evt_ioe),
        .desc_done  (evt_desc_done),
        .fifo_empty (evt_fifo_empty),
        .evt_valid  (evt_ok)
    );

    always_comb begin
        reload_req = wr_load | (tmr_fire & cfg_dly_en);
    end

    irq_coal_down #(
        .CNT_W   (CNT_W),
        .RST_VAL (RST_THRESH)
    ) u_down (
        .clk      (clk),
        .rst_n    (rst_n),
        .thr_we   (wr_thr_we),
        .thr_wd   (wr_thr_data),
        .force_ld (reload_req),
        .evt      (evt_ok),
        .cnt_o    (coal_count),
        .thr_o    (thr_value),
        .term_o   (terminal)
    );

    irq_pend_updn #(
        .PEND_W (PEND_W)
    ) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (terminal),
        .ack    (wr_ack),
        .pend_o (pend_count)
    );

    always_comb begin
        irq_out = cfg_irq_en && (pend_count != '0);
    end
endmodule

// File: rtl/irq_coal_chk.sv
module irq_coal_chk #(
    parameter int CNT_W  = 8,
    parameter int PEND_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_load,
    input logic              wr_ack,
    input logic              tmr_fire,
    input logic              cfg_dly_en,
    input logic              cfg_irq_en,
    input logic              evt_desc_done,
    input logic              irq_out,
    input logic [CNT_W-1:0]  coal_count,
    input logic [CNT_W-1:0]  thr_value,
    input logic [PEND_W-1:0] pend_count
);
    localparam logic [PEND_W-1:0] PMAX = {PEND_W{1'b1}};

    AST_LOAD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_load |=> coal_count == $past(thr_value)); // R6

    AST_TMR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_fire && !cfg_dly_en && !wr_load && !evt_desc_done) |=> $stable(coal_count)); // R7

    AST_NO_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_desc_done && !wr_load && !tmr_fire) |=> $stable(coal_count)); // R3

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_irq_en |-> !irq_out); // R9

    AST_PEND_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_count == PMAX && !wr_ack) |=> pend_count == PMAX); // R11

    AST_ACK_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_count == '0) |=> pend_count <= PEND_W'(1)); // R10

    AST_PEND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_count == $past(pend_count))
              || (pend_count == $past(pend_count) + PEND_W'(1))
              || (pend_count == $past(pend_count) - PEND_W'(1))); // R4
endmodule

bind irq_coalesce_ctr irq_coal_chk #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_chk (.*);

// File: tb/irq_coalesce_ctr_test.sv
module irq_coalesce_ctr_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_thr_we;
    logic [7:0] wr_thr_data;
    logic       wr_load, wr_ack;
    logic       cfg_use_ioe, cfg_irq_en, cfg_dly_en;
    logic       evt_eof, evt_ioe, evt_desc_done, evt_fifo_empty, tmr_fire;
    logic       irq_out;
    logic [7:0] coal_count, thr_value;
    logic [3:0] pend_count;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    irq_coalesce_ctr uut (.*);

    // fields: use_ioe eof ioe done empty load tmr dly ack | coal | pend
    localparam int NV = 15;
    localparam logic [20:0] VEC [NV] = '{
        {9'b0_1_0_1_1_0_0_0_0, 8'd3, 4'd0},  // R2 frame end counts
        {9'b0_0_1_1_1_0_0_0_0, 8'd3, 4'd0},  // R2 flag ignored
        {9'b0_1_0_1_0_0_0_0_0, 8'd3, 4'd0},  // R3 fifo busy
        {9'b0_1_0_0_1_0_0_0_0, 8'd3, 4'd0},  // R3 desc not done
        {9'b1_0_1_1_1_0_0_0_0, 8'd2, 4'd0},  // R2 flag counts
        {9'b1_1_0_1_1_0_0_0_0, 8'd2, 4'd0},  // R2 frame end ignored
        {9'b0_1_0_1_1_0_0_0_0, 8'd1, 4'd0},  // R4
        {9'b0_1_0_1_1_0_0_0_0, 8'd4, 4'd1},  // R4 terminal
        {9'b0_1_0_1_1_0_0_0_0, 8'd3, 4'd1},  // R4
        {9'b0_0_0_0_0_0_1_0_0, 8'd3, 4'd1},  // R7 timer masked
        {9'b0_0_0_0_0_0_1_1_0, 8'd4, 4'd1},  // R7 timer reload
        {9'b0_1_0_1_1_0_0_0_0, 8'd3, 4'd1},  // R4
        {9'b0_1_0_1_1_1_0_0_0, 8'd4, 4'd1},  // R8 load beats event, R6
        {9'b0_0_0_0_0_0_0_0_1, 8'd4, 4'd0},  // R10 ack
        {9'b0_0_0_0_0_0_0_0_1, 8'd4, 4'd0}   // R10 ack at zero
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_thr_we = 0; wr_thr_data = 0; wr_load = 0; wr_ack = 0;
        evt_eof = 0; evt_ioe = 0; evt_desc_done = 0; evt_fifo_empty = 0;
        tmr_fire = 0;
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic event_pulse(input logic ack);
        idle();
        evt_eof = 1; evt_desc_done = 1; evt_fifo_empty = 1; wr_ack = ack;
        cyc();
        idle();
    endtask

    initial begin
        #100000;
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle();
        cfg_use_ioe = 0; cfg_irq_en = 1; cfg_dly_en = 0;
        rst_n = 0;
        cyc(); cyc();
        rst_n = 1;
        cyc();
        check("R1 coal", int'(coal_count), 4);
        check("R1 thr", int'(thr_value), 4);
        check("R1 pend", int'(pend_count), 0);
        check("R1 irq", int'(irq_out), 0);

        for (int i = 0; i < NV; i++) begin
            idle();
            {cfg_use_ioe, evt_eof, evt_ioe, evt_desc_done, evt_fifo_empty,
             wr_load, tmr_fire, cfg_dly_en, wr_ack} = VEC[i][20:12];
            cyc();
            check($sformatf("vec%0d coal", i), int'(coal_count), int'(VEC[i][11:4]));
            check($sformatf("vec%0d pend", i), int'(pend_count), int'(VEC[i][3:0]));
            check($sformatf("R9 vec%0d irq", i), int'(irq_out), int'(VEC[i][3:0] != 0));
        end
        idle(); cfg_use_ioe = 0; cfg_dly_en = 0;

        // R5: threshold write does not disturb the current count
        wr_thr_we = 1; wr_thr_data = 8'd2;
        cyc(); idle();
        check("R5 count kept", int'(coal_count), 4);
        check("R5 thr stored", int'(thr_value), 2);
        wr_load = 1; cyc(); idle();
        check("R6 load new thr", int'(coal_count), 2);
        event_pulse(0);
        check("R4 dec", int'(coal_count), 1);
        event_pulse(0);
        check("R4 terminal reload", int'(coal_count), 2);
        check("R4 pend up", int'(pend_count), 1);

        // R9: enable masks output
        cfg_irq_en = 0; #1;
        check("R9 masked", int'(irq_out), 0);
        cfg_irq_en = 1; #1;
        check("R9 enabled", int'(irq_out), 1);

        // threshold 0: every completion is terminal
        wr_thr_we = 1; wr_thr_data = 8'd0; wr_load = 1;
        cyc(); idle();
        wr_load = 1; cyc(); idle();
        check("R4 zero thr", int'(coal_count), 0);
        for (int k = 0; k < 20; k++) event_pulse(0);
        check("R11 saturate", int'(pend_count), 15);
        check("R11 coal reload", int'(coal_count), 0);
        event_pulse(1);
        check("R12 both at max", int'(pend_count), 15);
        wr_ack = 1; cyc(); idle();
        check("R10 ack dec", int'(pend_count), 14);
        event_pulse(1);
        check("R12 both mid", int'(pend_count), 14);
        event_pulse(0);
        check("R4 inc mid", int'(pend_count), 15);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule